// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave side of the serial bus of a small flash-style device. It watches the bus pins with the chip's own clock and takes one input bit on every rising serial-clock edge while the select line is low. It builds the first byte of each transfer into a command code and the bytes that follow into an argument. It drives status bytes back on the output pin while the status-read command runs. A hold input pauses a transfer part-way through without ending it.

When a transfer ends cleanly, the block hands one decoded command to a neighbouring status and protection unit as a one-cycle strobe, together with its argument. That unit supplies the status byte that the block streams out. The memory array, the erase and program timing and the protection policy all sit outside this block. Both clock polarities are supported: serial clock idling low (mode 0) and idling high (mode 3).

Top module: `spi_flash_cmd_frontend`

## Requirements
- R1: Following reset, `spi_so_oe` and `cmd_stb` are both low.
- R2: The bus is sampled on rising `spi_sclk` edges only, with the code arriving MSB first. The first byte after `spi_cs_n` falls is the command code. Decoding works in mode 0 and in mode 3. Codes: 0x06 write-enable gives `cmd_code` 1, 0x04 write-disable gives 2, 0xC7 chip erase gives 5.
- R3: After code 0x05 (status read), `spi_so_oe` is high and `spi_so` carries `status_i` MSB first. Each bit changes on a falling `spi_sclk` edge and is valid at the rising edge that follows.
- R4: The status byte repeats for as long as `spi_cs_n` stays low. `status_i` is sampled once at the start of each output byte, so a change made part-way through a byte first appears in the next byte.
- R5: While `spi_hold_n` is low with `spi_cs_n` low, `spi_so_oe` is low and `spi_sclk` and `spi_si` have no effect. When `spi_hold_n` returns high, the transfer continues from the bit where it stopped.
- R6: A strobed command raises `cmd_stb` for exactly one cycle after `spi_cs_n` rises. This happens only if the transfer held exactly the required number of whole bytes. A partial final byte, missing bytes or extra bytes produce no strobe.
- R7: A rising `spi_cs_n` drops any partial byte and any latched code, so the next transfer starts from its first bit.
- R8: Unsupported codes produce no strobe and leave `spi_so_oe` low for the whole transfer.
- R9: Code 0x20 (sector erase) takes three address bytes, MSB first. They appear as `cmd_arg[23:0]` with `cmd_code` 4. Code 0x01 (status write) takes one data byte, placed in `cmd_arg[7:0]` with `cmd_code` 3.
- R10: `spi_so_oe` is low whenever `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the bus master |
| spi_cs_n | input | 1 | Active-low device select |
| spi_si | input | 1 | Serial data from the master |
| spi_hold_n | input | 1 | Active-low transfer pause |
| status_i | input | 8 | Status byte supplied by the status unit |
| spi_so | output | 1 | Serial data to the master |
| spi_so_oe | output | 1 | Output enable for the external tri-state driver of `spi_so` |
| cmd_stb | output | 1 | One-cycle pulse for a completed command |
| cmd_code | output | 3 | Decoded command kind that goes with `cmd_stb` |
| cmd_arg | output | 24 | Argument bytes that go with `cmd_stb` |

## Verification
The bench runs the same commands with the serial clock idling low and with it idling high. A design that treats the first falling edge in mode 3 as a data edge would decode shifted codes.

It cuts transfers short in the middle of a byte and pads them with an extra byte. A front-end that strobes on byte count alone would then erase or unlock when it should not.

It changes the status input part-way through a streamed byte. A design that samples the status continuously would return a mixed byte.

It also pauses transfers with hold while toggling the clock and data lines. A design that keeps counting during the pause would misalign every later bit, and one that keeps driving would collide on the output.

// File: rtl/spifl_fe_pkg.sv
package spifl_fe_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 3;
    localparam int ARG_W      = BYTE_W * ADDR_BYTES;
    localparam int BIT_CNT_W  = $clog2(BYTE_W);
    localparam int BYTE_CNT_W = $clog2(ADDR_BYTES + 3);

    localparam logic [BYTE_W-1:0] OP_WR_EN      = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WR_DIS     = 8'h04;
    localparam logic [BYTE_W-1:0] OP_STAT_RD    = 8'h05;
    localparam logic [BYTE_W-1:0] OP_STAT_WR    = 8'h01;
    localparam logic [BYTE_W-1:0] OP_SECT_ERASE = 8'h20;
    localparam logic [BYTE_W-1:0] OP_CHIP_ERASE = 8'hC7;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_WR_EN      = 3'd1,
        CMD_WR_DIS     = 3'd2,
        CMD_STAT_WR    = 3'd3,
        CMD_SECT_ERASE = 3'd4,
        CMD_CHIP_ERASE = 3'd5,
        CMD_STAT_RD    = 3'd6
    } cmd_e;

    // Pin-level events after synchronisation, one bundle per clk cycle.
    typedef struct packed {
        logic sel;      // device selected
        logic act;      // selected and not paused
        logic rise;     // rising serial clock, counted
        logic fall;     // falling serial clock, counted
        logic si;       // synchronised data input
        logic cs_rise;  // deselect event
    } pin_ev_t;

    function automatic cmd_e decode_op(input logic [BYTE_W-1:0] op);
        case (op)
            OP_WR_EN:      return CMD_WR_EN;
            OP_WR_DIS:     return CMD_WR_DIS;
            OP_STAT_RD:    return CMD_STAT_RD;
            OP_STAT_WR:    return CMD_STAT_WR;
            OP_SECT_ERASE: return CMD_SECT_ERASE;
            OP_CHIP_ERASE: return CMD_CHIP_ERASE;
            default:       return CMD_NONE;
        endcase
    endfunction

    function automatic logic [BYTE_CNT_W-1:0] arg_bytes(input cmd_e c);
        case (c)
            CMD_STAT_WR:    return BYTE_CNT_W'(1);
            CMD_SECT_ERASE: return BYTE_CNT_W'(ADDR_BYTES);
            default:        return '0;
        endcase
    endfunction

    function automatic logic is_strobed(input cmd_e c);
        return (c != CMD_NONE) && (c != CMD_STAT_RD);
    endfunction

endpackage

// File: rtl/spifl_pin_sync.sv
module spifl_pin_sync
    import spifl_fe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk,
    input  logic    cs_n,
    input  logic    si,
    input  logic    hold_n,
    output pin_ev_t ev
);
    localparam int NPIN = 4;
    localparam logic [NPIN-1:0] IDLE_LVL = 4'b0101; // {sclk, cs_n, si, hold_n}

    logic [NPIN-1:0]   raw;
    logic [NPIN-1:0]   synced;
    logic [STAGES-1:0] chain [NPIN];

    assign raw = {sclk, cs_n, si, hold_n};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= {STAGES{IDLE_LVL[g]}};
            else     chain[g] <= {chain[g][STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[g][STAGES-1];
    end

    logic sclk_s, cs_s, si_s, hold_s;
    logic sclk_q, cs_q;
    assign {sclk_s, cs_s, si_s, hold_s} = synced;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;   // tracked during hold too, so no stale edge
            cs_q   <= cs_s;
        end
    end

    always_comb begin
        ev.sel     = !cs_s;
        ev.act     = !cs_s && hold_s;
        ev.rise    = ev.act && sclk_s && !sclk_q;
        ev.fall    = ev.act && !sclk_s && sclk_q;
        ev.si      = si_s;
        ev.cs_rise = cs_s && !cs_q;
    end

endmodule

// File: rtl/spifl_rx_framer.sv
module spifl_rx_framer
    import spifl_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pin_ev_t          ev,
    output logic             cmd_stb,
    output cmd_e             cmd_code,
    output logic [ARG_W-1:0] cmd_arg,
    output logic             rd_active
);
    localparam logic [BYTE_CNT_W-1:0] BYTE_MAX = '1;

    logic [BIT_CNT_W-1:0]  bit_cnt;
    logic [BYTE_CNT_W-1:0] byte_cnt;
    logic [BYTE_W-1:0]     rx_sr;
    logic [ARG_W-1:0]      arg_sr;
    cmd_e                  op;
    logic [BYTE_W-1:0]     byte_in;
    logic                  complete;

    assign byte_in  = {rx_sr[BYTE_W-2:0], ev.si};
    assign complete = (bit_cnt == '0) && is_strobed(op)
                   && (byte_cnt == BYTE_CNT_W'(1) + arg_bytes(op));

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            rx_sr     <= '0;
            arg_sr    <= '0;
            op        <= CMD_NONE;
            rd_active <= 1'b0;
            cmd_stb   <= 1'b0;
            cmd_code  <= CMD_NONE;
            cmd_arg   <= '0;
        end else begin
            cmd_stb <= 1'b0;
            if (ev.cs_rise) begin
                if (complete) begin
                    cmd_stb  <= 1'b1;
                    cmd_code <= op;
                    cmd_arg  <= arg_sr;
                end
                bit_cnt   <= '0;
                byte_cnt  <= '0;
                op        <= CMD_NONE;
                rd_active <= 1'b0;
                arg_sr    <= '0;
            end else if (!ev.sel) begin
                bit_cnt   <= '0;
                byte_cnt  <= '0;
                op        <= CMD_NONE;
                rd_active <= 1'b0;
            end else if (ev.rise) begin
                rx_sr   <= byte_in;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                    if (byte_cnt == '0) begin
                        op        <= decode_op(byte_in);
                        rd_active <= (decode_op(byte_in) == CMD_STAT_RD);
                    end else begin
                        arg_sr <= {arg_sr[ARG_W-BYTE_W-1:0], byte_in};
                    end
                    if (byte_cnt != BYTE_MAX) byte_cnt <= byte_cnt + 1'b1;
                end
            end
        end
    end

    // R6: a strobe only follows a deselect event
    a_r6_strobe_after_deselect: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> $past(ev.cs_rise));
    // R6: strobe lasts a single cycle
    a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |=> !cmd_stb);
    // R8: never strobe a non-command or the read code
    a_r8_strobe_kind_valid: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> (cmd_code != CMD_NONE && cmd_code != CMD_STAT_RD));
    // R5: a pause freezes the framing state
    a_r5_hold_freezes_framing: assert property (@(posedge clk) disable iff (rst)
        (ev.sel && !ev.act) |=> ($stable(bit_cnt) && $stable(rx_sr)));
    // R7: deselect leaves the framer idle
    a_r7_idle_when_deselected: assert property (@(posedge clk) disable iff (rst)
        !ev.sel |=> (bit_cnt == '0 && byte_cnt == '0 && !rd_active));

endmodule

// File: rtl/spifl_tx_status.sv
module spifl_tx_status
    import spifl_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev,
    input  logic              rd_active,
    input  logic [BYTE_W-1:0] status_i,
    output logic              so,
    output logic              so_oe
);
    logic [BYTE_W-2:0]    tx_sr;
    logic [BIT_CNT_W-1:0] out_cnt;
    logic                 driving;

    always_ff @(posedge clk) begin
        if (rst || !rd_active) begin
            tx_sr   <= '0;
            out_cnt <= '0;
            driving <= 1'b0;
            so      <= 1'b0;
        end else if (ev.fall) begin
            driving <= 1'b1;
            out_cnt <= out_cnt + 1'b1;
            if (out_cnt == '0) begin
                so    <= status_i[BYTE_W-1];      // byte start: fresh sample
                tx_sr <= status_i[BYTE_W-2:0];
            end else begin
                so    <= tx_sr[BYTE_W-2];
                tx_sr <= {tx_sr[BYTE_W-3:0], 1'b0};
            end
        end
    end

    assign so_oe = driving && ev.act;

    // R3: output bit changes only on a counted falling edge
    a_r3_so_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (rd_active && ev.sel && !ev.fall) |=> $stable(so));
    // R4: the byte position counter only advances on falling edges
    a_r4_out_cnt_on_fall: assert property (@(posedge clk) disable iff (rst)
        (rd_active && ev.sel && !ev.fall) |=> $stable(out_cnt));

endmodule

// File: rtl/spi_flash_cmd_frontend.sv
module spi_flash_cmd_frontend
    import spifl_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_si,
    input  logic        spi_hold_n,
    input  logic [7:0]  status_i,
    output logic        spi_so,
    output logic        spi_so_oe,
    output logic        cmd_stb,
    output logic [2:0]  cmd_code,
    output logic [23:0] cmd_arg
);
    pin_ev_t          ev;
    cmd_e             code_e;
    logic             rd_active;
    logic [ARG_W-1:0] arg_w;

    spifl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sclk   (spi_sclk),
        .cs_n   (spi_cs_n),
        .si     (spi_si),
        .hold_n (spi_hold_n),
        .ev     (ev)
    );

    spifl_rx_framer u_rx (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .cmd_stb   (cmd_stb),
        .cmd_code  (code_e),
        .cmd_arg   (arg_w),
        .rd_active (rd_active)
    );

    spifl_tx_status u_tx (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rd_active (rd_active),
        .status_i  (status_i),
        .so        (spi_so),
        .so_oe     (spi_so_oe)
    );

    assign cmd_code = code_e;
    assign cmd_arg  = arg_w;

    // R1: quiet immediately after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!cmd_stb && !spi_so_oe));

endmodule

// File: tb/spi_flash_cmd_frontend_test.sv
module spi_flash_cmd_frontend_test;
    localparam int H = 8;   // clk cycles per serial half period

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, spi_hold_n = 1'b1;
    logic [7:0]  status_i = 8'h00;
    logic        spi_so, spi_so_oe, cmd_stb;
    logic [2:0]  cmd_code;
    logic [23:0] cmd_arg;

    int checks = 0;
    int failures = 0;

    typedef struct { logic [2:0] code; logic [23:0] arg; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    spi_flash_cmd_frontend uut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .spi_hold_n(spi_hold_n), .status_i(status_i),
        .spi_so(spi_so), .spi_so_oe(spi_so_oe), .cmd_stb(cmd_stb),
        .cmd_code(cmd_code), .cmd_arg(cmd_arg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on every strobe.
    always @(negedge clk) begin
        if (!rst && cmd_stb) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected strobe", {29'd0, cmd_code}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R2/R9 strobe code", {29'd0, cmd_code}, {29'd0, e.code});
                check("R9 strobe arg", {8'd0, cmd_arg}, {8'd0, e.arg});
            end
        end
    end

    task automatic expect_cmd(input logic [2:0] c, input logic [23:0] a);
        exp_t e;
        e.code = c; e.arg = a;
        exp_q.push_back(e);
    endtask

    task automatic cs_begin(input logic mode3);
        spi_sclk = mode3;
        wait_clk(H);
        spi_cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_end(input logic mode3);
        if (!mode3) spi_sclk = 1'b0;
        wait_clk(H);
        spi_cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic hold_pause(input int toggles, input logic junk);
        spi_hold_n = 1'b0;
        wait_clk(H);
        check("R5 oe low during hold", {31'd0, spi_so_oe}, 32'd0);
        for (int k = 0; k < toggles; k++) begin
            spi_sclk = 1'b0; spi_si = junk; wait_clk(H);
            spi_sclk = 1'b1; wait_clk(H);
        end
        wait_clk(H);
        spi_hold_n = 1'b1;
        wait_clk(H);
    endtask

    // One byte, MSB first. Optional hold before bit hold_at and a status
    // change before bit chg_at (values >= 8 disable them). nbits < 8 cuts it.
    task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                        input int chg_at, input logic [7:0] chg_val,
                        output logic [7:0] rx, output logic oe_all, output logic oe_any);
        rx = 8'h00; oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            if (i == hold_at) hold_pause(3, ~tx[7-i]);
            if (i == chg_at) status_i = chg_val;
            spi_sclk = 1'b0;
            spi_si = tx[7-i];
            wait_clk(H);
            rx = {rx[6:0], spi_so};
            oe_all &= spi_so_oe;
            oe_any |= spi_so_oe;
            spi_sclk = 1'b1;
            wait_clk(H);
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] r; logic a, b;
        xfer(tx, 8, 99, 99, 8'h00, r, a, b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] r; logic oa, on;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        check("R1 oe after reset", {31'd0, spi_so_oe}, 32'd0);
        check("R1 strobe after reset", {31'd0, cmd_stb}, 32'd0);

        // R2 mode 0 write enable, mode 3 write disable, chip erase
        expect_cmd(3'd1, 24'h0);
        cs_begin(0); send(8'h06); cs_end(0);
        expect_cmd(3'd2, 24'h0);
        cs_begin(1); send(8'h04); cs_end(1);
        expect_cmd(3'd5, 24'h0);
        cs_begin(1); send(8'hC7); cs_end(1);

        // R9 sector erase address and status write data
        expect_cmd(3'd4, 24'h123456);
        cs_begin(0); send(8'h20); send(8'h12); send(8'h34); send(8'h56); cs_end(0);
        expect_cmd(3'd3, 24'h0000A5);
        cs_begin(1); send(8'h01); send(8'hA5); cs_end(1);

        // R6 partial final byte, extra byte, missing address byte: no strobe
        cs_begin(0); send(8'h06); xfer(8'hFF, 3, 99, 99, 8'h00, r, oa, on); cs_end(0);
        cs_begin(0); send(8'h06); send(8'h00); cs_end(0);
        cs_begin(1); send(8'h20); send(8'h12); send(8'h34); cs_end(1);
        // R7 partial opcode then a fresh transfer decodes cleanly
        cs_begin(0); xfer(8'h20, 5, 99, 99, 8'h00, r, oa, on); cs_end(0);
        expect_cmd(3'd1, 24'h0);
        cs_begin(0); send(8'h06); cs_end(0);
        check("R6/R7 scoreboard drained", exp_q.size(), 32'd0);

        // R8 unknown code: no strobe, output never enabled
        cs_begin(0);
        xfer(8'h9F, 8, 99, 99, 8'h00, r, oa, on);
        xfer(8'h00, 8, 99, 99, 8'h00, r, oa, on);
        check("R8 oe stays low on unknown code", {31'd0, on}, 32'd0);
        cs_end(0);

        // R3/R4 status read, repeated, both modes
        status_i = 8'h81;
        cs_begin(0); send(8'h05);
        for (int b = 0; b < 3; b++) begin
            xfer(8'h00, 8, 99, 99, 8'h00, r, oa, on);
            check("R3/R4 status byte mode0", {24'd0, r}, 32'h81);
            check("R3 oe during status", {31'd0, oa}, 32'd1);
        end
        cs_end(0);
        // R10 deselected output off
        check("R10 oe after deselect", {31'd0, spi_so_oe}, 32'd0);
        status_i = 8'h02;
        cs_begin(1); send(8'h05);
        xfer(8'h00, 8, 99, 99, 8'h00, r, oa, on);
        check("R3 status byte mode3", {24'd0, r}, 32'h02);
        xfer(8'h00, 8, 99, 99, 8'h00, r, oa, on);
        check("R4 status repeat mode3", {24'd0, r}, 32'h02);
        cs_end(1);

        // R4 refresh only at byte boundary
        status_i = 8'h01;
        cs_begin(0); send(8'h05);
        xfer(8'h00, 8, 99, 3, 8'hF0, r, oa, on);
        check("R4 old value kept mid-byte", {24'd0, r}, 32'h01);
        xfer(8'h00, 8, 99, 99, 8'h00, r, oa, on);
        check("R4 new value next byte", {24'd0, r}, 32'hF0);
        cs_end(0);

        // R5 hold during status output and during a data byte
        status_i = 8'h5A;
        cs_begin(0); send(8'h05);
        xfer(8'h00, 8, 4, 99, 8'h00, r, oa, on);
        check("R5 status intact across hold", {24'd0, r}, 32'h5A);
        cs_end(0);
        expect_cmd(3'd3, 24'h00003C);
        cs_begin(1); send(8'h01);
        xfer(8'h3C, 8, 4, 99, 8'h00, r, oa, on);
        cs_end(1);

        wait_clk(4 * H);
        check("R6 all expected strobes seen", exp_q.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule